// File: doc/BRIEF.md
# Lockstep Partner Bus Master Sequencer

This block is the bus-master engine of one board in a pair of partner boards that run in lockstep on a shared, wired-OR system bus. A command enters on a valid/ready stream. The block then raises a bus request and waits for the arbiter's grant. After the grant it runs a read or write with fixed timing: the address goes out one tick after the grant, data moves two ticks after the address, and read data is handed back one tick after that. Both partners receive the same commands, so in normal operation they drive identical values in the same cycles.

Every cycle each board sends its partner a short digest of its sequencer phase, direction and latched address, and compares the digest it receives with its own. The two boards have fixed roles. When the digests differ, the board built as the lower slot takes itself off-line at once. It drops its transaction, drives zero on every bus output and ignores the grant. The higher-slot board never reacts to a mismatch and finishes its transaction on its own, with no takeover step. An off-line board comes back when `rejoin` is high in a cycle where the partner reports idle, so both boards start the next command together.

The command stream follows valid/ready rules. A command is taken in a cycle where `cmd_valid` and `cmd_ready` are both high, and `cmd_ready` is high only while the sequencer is idle and on-line. The response output has no ready. Bus timing is fixed and cannot stall, so the consumer must take `rsp_valid` in the cycle it is shown.

Top module: `lockstep_bus_seq`

## Requirements
- R1: After reset, `offline` and `rsp_valid` are 0, every bus output is 0, and `cmd_ready` and `idle_out` are 1.
- R2: A command is accepted in a cycle with `cmd_valid` and `cmd_ready` both high. `cmd_ready` is 1 only when the board is idle and on-line. `bus_req` is 1 from the cycle after acceptance up to and including the first cycle in which `bus_gnt` is seen high.
- R3: In the cycle after a cycle with `bus_req` and `bus_gnt` both high, the board drives one address-phase cycle: `bus_addr_vld`=1, `bus_addr` set to the command address, and `bus_wr`=1 for a write or 0 for a read. `bus_req` is 0 from that cycle on.
- R4: For a write, `bus_data_oe`=1 and `bus_data_out` carries the write data in the single cycle two cycles after the address phase.
- R5: For a read, `bus_data_in` is sampled in the cycle two cycles after the address phase. In the next cycle `rsp_valid`=1 for one cycle with that value on `rsp_rdata`. A write produces no response.
- R6: Outside its own phase, each bus output (`bus_req`, `bus_addr_vld`, `bus_addr`, `bus_wr`, `bus_data_oe`, `bus_data_out`) is 0, so it never disturbs the wired-OR bus.
- R7: `sync_out` is {phase code[2:0], write flag, XOR fold of the latched address}. The phase codes are idle=0, request=1, address=2, gap=3, data=4, and every idle board sends 0. If a lower-slot board (`LOW_SLOT`=1) is on-line and `sync_in` differs from `sync_out` in a cycle, `offline`=1 from the next cycle, its transaction is dropped, and no response follows.
- R8: A higher-slot board (`LOW_SLOT`=0) never goes off-line. A mismatch does not change its transaction, which completes with the correct read data.
- R9: While `offline`=1, every bus output and `cmd_ready` are 0, and `bus_gnt`, `cmd_valid` and `sync_in` have no effect.
- R10: An off-line board clears `offline` in the cycle after a cycle with `rejoin`=1 and `partner_idle`=1. `rejoin` asserted while `partner_idle`=0 has no effect.
- R11: `idle_out` is 1 exactly when the sequencer is in its idle phase. This includes the whole time the board is off-line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command stream valid |
| cmd_ready | output | 1 | Command stream ready |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | ADDR_W | Command address |
| cmd_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle read response strobe |
| rsp_rdata | output | DATA_W | Read response data |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant from the arbiter |
| bus_addr_vld | output | 1 | Address phase marker |
| bus_addr | output | ADDR_W | Bus address |
| bus_wr | output | 1 | Bus direction in address phase |
| bus_data_oe | output | 1 | Write data phase marker |
| bus_data_out | output | DATA_W | Write data to bus |
| bus_data_in | input | DATA_W | Data from bus |
| sync_out | output | DIGEST_W | State digest sent to partner |
| sync_in | input | DIGEST_W | Partner's state digest |
| idle_out | output | 1 | Sequencer idle, sent to partner |
| partner_idle | input | 1 | Partner sequencer idle |
| rejoin | input | 1 | Request to return on-line |
| offline | output | 1 | Board is off-line |

## Verification
The bench runs two instances as lower and higher partner on a modelled wired-OR bus. It corrupts the digest in the gap cycle of a read. A design that did not drop at once would drive stale data or return a response. A design that let the higher board react would lose the transaction altogether. While the partner is busy, the bench pulses `rejoin` to catch a board that rejoins mid-transaction and falls out of phase. Reads that follow writes, with several grant delays, expose any phase that is off by one tick against the fixed address-to-data spacing.

// File: rtl/lsb_pkg.sv
package lsb_pkg;
  localparam int PH_W = 3;
  typedef enum logic [PH_W-1:0] {
    PH_IDLE = 3'd0,
    PH_REQ  = 3'd1,
    PH_ADDR = 3'd2,
    PH_GAP  = 3'd3,
    PH_DATA = 3'd4
  } phase_t;
endpackage

// File: rtl/lsb_phase_fsm.sv
module lsb_phase_fsm
  import lsb_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              drop,
  input  logic              online,
  input  logic              cmd_valid,
  input  logic              cmd_write,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              cmd_ready,
  input  logic              bus_gnt,
  input  logic [DATA_W-1:0] bus_rdata,
  output phase_t            phase,
  output logic [ADDR_W-1:0] lat_addr,
  output logic              lat_wr,
  output logic [DATA_W-1:0] lat_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);
  assign cmd_ready = online && (phase == PH_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      lat_addr  <= '0;
      lat_wr    <= 1'b0;
      lat_wdata <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (drop) begin
        phase     <= PH_IDLE;
        lat_addr  <= '0;
        lat_wr    <= 1'b0;
        lat_wdata <= '0;
      end else begin
        unique case (phase)
          PH_IDLE: if (cmd_valid && cmd_ready) begin
            phase     <= PH_REQ;
            lat_addr  <= cmd_addr;
            lat_wr    <= cmd_write;
            lat_wdata <= cmd_wdata;
          end
          PH_REQ:  if (bus_gnt) phase <= PH_ADDR;
          PH_ADDR: phase <= PH_GAP;
          PH_GAP:  phase <= PH_DATA;
          PH_DATA: begin
            if (!lat_wr) begin
              rsp_valid <= 1'b1;
              rsp_rdata <= bus_rdata;
            end
            phase     <= PH_IDLE;
            lat_addr  <= '0;
            lat_wr    <= 1'b0;
            lat_wdata <= '0;
          end
          default: phase <= PH_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/lsb_sync_check.sv
module lsb_sync_check
  import lsb_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DIGEST_W  = 8,
  parameter bit LOW_SLOT  = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  phase_t              phase,
  input  logic                lat_wr,
  input  logic [ADDR_W-1:0]   lat_addr,
  input  logic [DIGEST_W-1:0] sync_in,
  input  logic                rejoin,
  input  logic                partner_idle,
  output logic [DIGEST_W-1:0] sync_out,
  output logic                drop,
  output logic                offline
);
  localparam int FOLD_W = DIGEST_W - PH_W - 1;

  function automatic logic [FOLD_W-1:0] fold_addr(input logic [ADDR_W-1:0] a);
    logic [FOLD_W-1:0] f;
    f = '0;
    for (int i = 0; i < ADDR_W; i++) begin
      f[i % FOLD_W] = f[i % FOLD_W] ^ a[i];
    end
    return f;
  endfunction

  assign sync_out = {phase, lat_wr, fold_addr(lat_addr)};

  generate
    if (LOW_SLOT) begin : g_low
      logic off_q;
      assign drop    = !off_q && (sync_in != sync_out);
      assign offline = off_q;
      always_ff @(posedge clk) begin
        if (!rst_n)                                  off_q <= 1'b0;
        else if (drop)                               off_q <= 1'b1;
        else if (off_q && rejoin && partner_idle)    off_q <= 1'b0;
      end
    end else begin : g_high
      assign drop    = 1'b0;
      assign offline = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/lsb_bus_drive.sv
module lsb_bus_drive
  import lsb_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  phase_t            phase,
  input  logic              offline,
  input  logic [ADDR_W-1:0] lat_addr,
  input  logic              lat_wr,
  input  logic [DATA_W-1:0] lat_wdata,
  output logic              bus_req,
  output logic              bus_addr_vld,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_wr,
  output logic              bus_data_oe,
  output logic [DATA_W-1:0] bus_data_out
);
  logic in_addr, in_wdata;
  assign in_addr  = !offline && (phase == PH_ADDR);
  assign in_wdata = !offline && (phase == PH_DATA) && lat_wr;

  assign bus_req      = !offline && (phase == PH_REQ);
  assign bus_addr_vld = in_addr;
  assign bus_addr     = in_addr ? lat_addr : '0;
  assign bus_wr       = in_addr && lat_wr;
  assign bus_data_oe  = in_wdata;
  assign bus_data_out = in_wdata ? lat_wdata : '0;
endmodule

// File: rtl/lockstep_bus_seq.sv
module lockstep_bus_seq
  import lsb_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 16,
  parameter int DIGEST_W = 8,
  parameter bit LOW_SLOT = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_valid,
  output logic                cmd_ready,
  input  logic                cmd_write,
  input  logic [ADDR_W-1:0]   cmd_addr,
  input  logic [DATA_W-1:0]   cmd_wdata,
  output logic                rsp_valid,
  output logic [DATA_W-1:0]   rsp_rdata,
  output logic                bus_req,
  input  logic                bus_gnt,
  output logic                bus_addr_vld,
  output logic [ADDR_W-1:0]   bus_addr,
  output logic                bus_wr,
  output logic                bus_data_oe,
  output logic [DATA_W-1:0]   bus_data_out,
  input  logic [DATA_W-1:0]   bus_data_in,
  output logic [DIGEST_W-1:0] sync_out,
  input  logic [DIGEST_W-1:0] sync_in,
  output logic                idle_out,
  input  logic                partner_idle,
  input  logic                rejoin,
  output logic                offline
);
  phase_t            phase;
  logic [ADDR_W-1:0] lat_addr;
  logic              lat_wr;
  logic [DATA_W-1:0] lat_wdata;
  logic              drop;

  assign idle_out = (phase == PH_IDLE);

  lsb_phase_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .drop(drop), .online(!offline),
    .cmd_valid(cmd_valid), .cmd_write(cmd_write), .cmd_addr(cmd_addr),
    .cmd_wdata(cmd_wdata), .cmd_ready(cmd_ready), .bus_gnt(bus_gnt),
    .bus_rdata(bus_data_in), .phase(phase), .lat_addr(lat_addr),
    .lat_wr(lat_wr), .lat_wdata(lat_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata)
  );

  lsb_sync_check #(.ADDR_W(ADDR_W), .DIGEST_W(DIGEST_W), .LOW_SLOT(LOW_SLOT)) u_sync (
    .clk(clk), .rst_n(rst_n), .phase(phase), .lat_wr(lat_wr),
    .lat_addr(lat_addr), .sync_in(sync_in), .rejoin(rejoin),
    .partner_idle(partner_idle), .sync_out(sync_out), .drop(drop),
    .offline(offline)
  );

  lsb_bus_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_drv (
    .phase(phase), .offline(offline), .lat_addr(lat_addr), .lat_wr(lat_wr),
    .lat_wdata(lat_wdata), .bus_req(bus_req), .bus_addr_vld(bus_addr_vld),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_data_oe(bus_data_oe),
    .bus_data_out(bus_data_out)
  );
endmodule

// File: rtl/lsb_seq_chk.sv
module lsb_seq_chk #(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 16,
  parameter int DIGEST_W = 8,
  parameter bit LOW_SLOT = 1'b1
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cmd_ready,
  input logic                rsp_valid,
  input logic                bus_req,
  input logic                bus_gnt,
  input logic                bus_addr_vld,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic                bus_wr,
  input logic                bus_data_oe,
  input logic [DATA_W-1:0]   bus_data_out,
  input logic [DIGEST_W-1:0] sync_out,
  input logic [DIGEST_W-1:0] sync_in,
  input logic                idle_out,
  input logic                partner_idle,
  input logic                rejoin,
  input logic                offline
);
  // R9
  off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    offline |-> (!bus_req && !bus_addr_vld && bus_addr == '0 && !bus_wr &&
                 !bus_data_oe && bus_data_out == '0 && !cmd_ready));
  // R3
  addr_after_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_gnt) |=> (bus_addr_vld || offline));
  // R4
  wdata_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr_vld && bus_wr) |=> ##1 (bus_data_oe || offline));
  // R6
  addr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_addr_vld |=> (!bus_addr_vld && !bus_req));
  // R5
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  // R10
  rejoin_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(offline) |-> $past(rejoin && partner_idle));
  // R11
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> idle_out);

  generate
    if (LOW_SLOT) begin : g_low_chk
      // R7
      drop_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(offline) |-> $past(sync_in != sync_out));
    end else begin : g_high_chk
      // R8
      never_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !offline);
    end
  endgenerate
endmodule

bind lockstep_bus_seq lsb_seq_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DIGEST_W(DIGEST_W), .LOW_SLOT(LOW_SLOT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_ready(cmd_ready), .rsp_valid(rsp_valid),
  .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_addr_vld(bus_addr_vld),
  .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_data_oe(bus_data_oe),
  .bus_data_out(bus_data_out), .sync_out(sync_out), .sync_in(sync_in),
  .idle_out(idle_out), .partner_idle(partner_idle), .rejoin(rejoin),
  .offline(offline)
);

// File: tb/lockstep_bus_seq_tb.sv
`timescale 1ns/1ps
module lockstep_bus_seq_tb;
  logic clk = 0;
  always #5 clk = ~clk;

  logic        rst_n = 0;
  logic        cmd_valid = 0, cmd_write = 0;
  logic [15:0] cmd_addr = 0, cmd_wdata = 0;
  logic        gnt = 0, rejoin = 0;
  logic [15:0] bus_rd = 0;
  logic [7:0]  inj_d = 0, inj_p = 0;

  logic d_ready, d_rv, d_req, d_av, d_wr, d_oe, d_idle, d_off;
  logic [15:0] d_rd, d_addr, d_do;
  logic [7:0]  d_sync;
  logic p_ready, p_rv, p_req, p_av, p_wr, p_oe, p_idle, p_off;
  logic [15:0] p_rd, p_addr, p_do;
  logic [7:0]  p_sync;

  lockstep_bus_seq #(.LOW_SLOT(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(d_ready),
    .cmd_write(cmd_write), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .rsp_valid(d_rv), .rsp_rdata(d_rd), .bus_req(d_req), .bus_gnt(gnt),
    .bus_addr_vld(d_av), .bus_addr(d_addr), .bus_wr(d_wr), .bus_data_oe(d_oe),
    .bus_data_out(d_do), .bus_data_in(bus_rd), .sync_out(d_sync),
    .sync_in(p_sync ^ inj_d), .idle_out(d_idle), .partner_idle(p_idle),
    .rejoin(rejoin), .offline(d_off));

  lockstep_bus_seq #(.LOW_SLOT(1'b0)) u_peer (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(p_ready),
    .cmd_write(cmd_write), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .rsp_valid(p_rv), .rsp_rdata(p_rd), .bus_req(p_req), .bus_gnt(gnt),
    .bus_addr_vld(p_av), .bus_addr(p_addr), .bus_wr(p_wr), .bus_data_oe(p_oe),
    .bus_data_out(p_do), .bus_data_in(bus_rd), .sync_out(p_sync),
    .sync_in(d_sync ^ inj_p), .idle_out(p_idle), .partner_idle(d_idle),
    .rejoin(1'b0), .offline(p_off));

  int errors = 0, checks = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // wired-OR bus
  wire        or_req = d_req | p_req;
  wire        or_av  = d_av | p_av;
  wire [15:0] or_addr = d_addr | p_addr;
  wire        or_wr  = d_wr | p_wr;
  wire [15:0] or_do  = d_do | p_do;

  // arbiter
  int gdelay = 0, gcnt = 0;
  always @(negedge clk) begin
    if (gnt) begin gnt = 0; gcnt = 0; end
    else if (or_req) begin
      if (gcnt >= gdelay) gnt = 1; else gcnt++;
    end
  end

  // memory responder
  logic [15:0] mem [16];
  logic [15:0] exp_mem [16];
  int mst = 0;
  logic [3:0] pa;
  bit pw;
  always @(negedge clk) begin
    if (mst == 0 && or_av) begin pa = or_addr[3:0]; pw = or_wr; mst = 1; end
    else if (mst == 1) begin bus_rd = pw ? 16'h0 : mem[pa]; mst = 2; end
    else if (mst == 2) begin if (pw) mem[pa] = or_do; mst = 3; end
    else if (mst == 3) begin bus_rd = 16'h0; mst = 0; end
  end

  // behavioural reference for u_dut: 0 idle,1 wait grant,2 address,3 gap,4 data
  int m_ph = 0;
  bit m_off = 0, m_wr = 0, m_rv = 0;
  logic [15:0] m_addr = 0, m_wd = 0, m_rd = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_off = 0; m_wr = 0; m_rv = 0; m_addr = 0; m_wd = 0;
    end else begin
      m_rv = 0;
      if (m_off) begin
        if (rejoin && p_idle) m_off = 0;
      end else if (inj_d != 0) begin
        m_off = 1; m_ph = 0;
      end else begin
        case (m_ph)
          0: if (cmd_valid) begin m_ph = 1; m_addr = cmd_addr; m_wr = cmd_write; m_wd = cmd_wdata; end
          1: if (gnt) m_ph = 2;
          2: m_ph = 3;
          3: m_ph = 4;
          default: begin
            if (!m_wr) begin m_rv = 1; m_rd = bus_rd; end
            m_ph = 0;
          end
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(d_ready == (!m_off && m_ph == 0), "R2", "cmd_ready", d_ready, !m_off && m_ph == 0);
      chk(d_req == (m_ph == 1), "R2", "bus_req", d_req, m_ph == 1);
      chk(d_av == (m_ph == 2) && d_addr == ((m_ph == 2) ? m_addr : 16'h0) &&
          d_wr == (m_ph == 2 && m_wr), "R3 R6", "address phase",
          {d_av, d_wr, d_addr}, {m_ph == 2, m_ph == 2 && m_wr, (m_ph == 2) ? m_addr : 16'h0});
      chk(d_oe == (m_ph == 4 && m_wr) && d_do == ((m_ph == 4 && m_wr) ? m_wd : 16'h0),
          "R4 R6", "write data", {d_oe, d_do}, {m_ph == 4 && m_wr, (m_ph == 4 && m_wr) ? m_wd : 16'h0});
      chk(d_off == m_off, "R7 R9", "offline", d_off, m_off);
      chk(d_idle == (m_ph == 0), "R11", "idle_out", d_idle, m_ph == 0);
      chk(d_rv == m_rv && (!m_rv || d_rd == m_rd), "R5", "response",
          {d_rv, d_rd}, {m_rv, m_rd});
      chk(!p_off, "R8", "peer offline", p_off, 0);
    end
  end

  task automatic run(input bit wr, input logic [15:0] a, input logic [15:0] d,
                     input int dly, input int inj_at, input int rj_at, input bit dut_on);
    int k;
    gdelay = dly;
    @(negedge clk);
    while (!p_ready) @(negedge clk);
    cmd_valid = 1; cmd_write = wr; cmd_addr = a; cmd_wdata = d;
    @(negedge clk);
    cmd_valid = 0;
    k = 1;
    while (!p_idle) begin
      inj_d  = (inj_at > 0 && k == inj_at) ? 8'h01 : 8'h00;
      inj_p  = (inj_at < 0 && k == -inj_at) ? 8'h10 : 8'h00;
      rejoin = (rj_at > 0 && k == rj_at);
      if (rj_at > 0 && k == rj_at + 1)
        chk(d_off == 1'b1, "R10", "rejoin while partner busy", d_off, 1);
      @(negedge clk);
      k++;
    end
    inj_d = 0; inj_p = 0; rejoin = 0;
    if (!wr) begin
      chk(p_rv && p_rd == exp_mem[a[3:0]], "R8", "peer read data", {p_rv, p_rd}, {1'b1, exp_mem[a[3:0]]});
      if (dut_on)
        chk(d_rv && d_rd == exp_mem[a[3:0]], "R5", "read data", {d_rv, d_rd}, {1'b1, exp_mem[a[3:0]]});
      else
        chk(!d_rv, "R7", "no response after drop", d_rv, 0);
    end else begin
      exp_mem[a[3:0]] = d;
      chk(!d_rv && !p_rv, "R5", "write has no response", {d_rv, p_rv}, 0);
    end
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin
      mem[i] = 16'h1000 + 16'(i) * 16'h0101;
      exp_mem[i] = mem[i];
    end
    repeat (4) @(negedge clk);
    chk(d_ready && d_idle && !d_off && !d_rv && !d_req && !d_av && !d_oe &&
        d_addr == 0 && d_do == 0, "R1", "state during reset",
        {d_ready, d_idle, d_off, d_rv, d_req, d_av, d_oe}, 7'b1100000);
    rst_n = 1;
    @(negedge clk);
    chk(d_ready && d_idle && !d_off && d_sync == 0, "R1", "state after reset",
        {d_ready, d_idle, d_off, d_sync}, {3'b110, 8'h00});
    run(1, 16'h0003, 16'hA5A5, 0, 0, 0, 1);
    run(1, 16'h00F7, 16'h5A3C, 3, 0, 0, 1);
    run(0, 16'h0003, 0, 1, 0, 0, 1);
    run(0, 16'h00F7, 0, 0, 0, 0, 1);
    run(0, 16'h000C, 0, 5, 0, 0, 1);
    // R7: corrupt digest in the gap cycle of a read
    run(0, 16'h0003, 0, 0, 3, 0, 0);
    chk(d_off, "R7", "low board off-line after mismatch", d_off, 1);
    // R9: peer alone writes and reads while this board stays quiet
    run(1, 16'h0005, 16'hBEEF, 2, 0, 0, 0);
    run(0, 16'h0005, 0, 4, 0, 2, 0);
    chk(d_off, "R9", "still off-line", d_off, 1);
    // R10: rejoin with partner idle
    @(negedge clk);
    rejoin = 1;
    @(negedge clk);
    rejoin = 0;
    chk(!d_off && d_ready, "R10", "back on-line", {d_off, d_ready}, 2'b01);
    run(0, 16'h0005, 0, 1, 0, 0, 1);
    run(1, 16'h0009, 16'h1234, 0, 0, 0, 1);
    // R8: corrupt the digest seen by the higher-slot board
    run(0, 16'h0009, 0, 2, -2, 0, 1);
    chk(!p_off && !d_off, "R8", "both stay on-line", {p_off, d_off}, 0);
    run(0, 16'h00F7, 0, 0, 0, 0, 1);
    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual=%0d expected=<20000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule